// File: doc/BRIEF.md
# SD Host System-DMA Transfer Engine

This block is the system-DMA slice of an SD host controller. Software programs a start address, a block size with an address-boundary code, a block count and a transfer mode through a narrow register write port. A mode write with DMA enabled starts the engine. It then issues one word-sized memory request per data beat: a write to memory when data comes from the card, a read from memory when data goes to the card. The request address steps by one word after each accepted beat.

The engine counts beats into blocks and blocks into a transfer. When the next address would sit on the programmed power-of-two boundary, it stops issuing requests and raises a DMA-pause status bit. It waits there until software writes a new address. After the final block it raises transfer-complete. An error from the data path ends the transfer and raises an error bit. Status bits stay set until software writes 1 to them.

The memory request side is a valid/ready stream. `mem_valid` is high for the whole time the engine is running and not paused. While `mem_valid` is high and `mem_ready` is low, the request holds: `mem_valid` stays high and `mem_addr` does not change. The only exception is the error input, which withdraws the request. A beat is transferred on every clock edge where both signals are high. The consumer may hold `mem_ready` low for any number of cycles.

Top module: `sdma_engine`

## Requirements
- R1: After reset, `busy`, `mem_valid`, all three status outputs, `blocks_left` and `mem_addr` are all zero.
- R2: Register selects are 0 address, 1 block size, 2 block count, 3 mode, 4 host control and 5 status. A mode write starts a transfer only when all three of these hold: mode bit 0 (DMA enable) is 1; host-control bits [4:3] (DMA select) hold 00; and the write does not set both bit 5 (multi-block) and bit 1 (count enable) while the block count is zero. Any other mode write starts nothing.
- R3: While running, each accepted beat uses the current `mem_addr`, and the next request address is one word (4 bytes) higher. A request that is not accepted keeps `mem_valid` high and `mem_addr` stable.
- R4: Block-size bits [11:0] give bytes per block. A block takes ceil(size/4) beats, and a size below 4 takes one beat. With count enable set, `blocks_left` drops by one at the end of each block, but it never goes below zero.
- R5: With the multi-block bit clear, the transfer ends after one block. With the multi-block bit and count enable both set, the transfer ends when the count reaches zero. At the end, status bit 0 (transfer complete) is set and `busy` falls.
- R6: Block-size bits [14:12] hold a code c, and the boundary is 4096 << c bytes. After a beat that is not the final beat, if the next address is a multiple of the boundary, the engine pauses: status bit 3 (DMA pause) is set and `mem_valid` stays low.
- R7: An address write while idle or paused loads the address, and a write while paused also resumes from that address. An address write while running is ignored.
- R8: A transfer whose final beat lands exactly on a boundary sets transfer complete and does not set DMA pause.
- R9: A write to select 5 clears each status bit (0, 3, 15) whose data bit is 1. Data bits that are 0 leave their status bits unchanged.
- R10: `data_err` while busy ends the transfer and sets status bit 15 (error) without setting transfer complete. While idle, `data_err` has no effect.
- R11: Writes to block size, block count, mode and host control while busy are ignored.
- R12: With the multi-block bit set and count enable clear, the transfer runs block after block without ending and `blocks_left` does not change.
- R13: `mem_write` equals mode bit 4: 1 means card-to-memory, so the engine writes memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_addr | output | 32 | Byte address of the current beat |
| mem_write | output | 1 | 1 = write memory, 0 = read memory |
| data_err | input | 1 | Data-path error |
| busy | output | 1 | Transfer active (running or paused) |
| blocks_left | output | 16 | Current block count |
| sts_xfer_done | output | 1 | Transfer-complete status |
| sts_dma_pause | output | 1 | Boundary-pause status |
| sts_error | output | 1 | Error status |

## Verification
Directed transfers separate the end conditions. One transfer is single-block with a count still left over. One has its count run out. One runs endlessly with counting off and is stopped only by an error. One ends exactly on a boundary, which tells pause apart from completion. Start addresses sit just below 4 KiB and 8 KiB boundaries under both boundary codes, so a pause must come at exactly the right beat and resume from the new address. Odd and zero block sizes test the beat rounding. Random stall patterns on `mem_ready`, and writes made while running, show that requests hold under back-pressure and that configuration cannot change mid-transfer.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

  typedef enum logic [2:0] {
    SEL_ADDR   = 3'd0,
    SEL_BSIZE  = 3'd1,
    SEL_BCNT   = 3'd2,
    SEL_MODE   = 3'd3,
    SEL_HCTL   = 3'd4,
    SEL_STATUS = 3'd5
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_PAUSE = 2'd2
  } eng_state_e;

  localparam int MODE_DMA_EN = 0;
  localparam int MODE_CNT_EN = 1;
  localparam int MODE_DIR    = 4;
  localparam int MODE_MULTI  = 5;
  localparam int HCTL_SEL_LO = 3;

  localparam int STS_DONE_BIT = 0;
  localparam int STS_DMA_BIT  = 3;
  localparam int STS_ERR_BIT  = 15;

  localparam int STS_NUM  = 3;
  localparam int STS_DONE = 0;
  localparam int STS_DMA  = 1;
  localparam int STS_ERR  = 2;

endpackage

// File: rtl/sdma_cfg.sv
module sdma_cfg
  import sdma_pkg::*;
#(
  parameter int SIZE_W    = 12,
  parameter int BND_W     = 3,
  parameter int WORD_LOG2 = 2,
  localparam int CFG_W    = SIZE_W + BND_W,
  localparam int BEAT_W   = SIZE_W + 1 - WORD_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic [CFG_W-1:0]  wdata,
  input  logic              count_zero,
  output logic [BEAT_W-1:0] blk_beats,
  output logic [BND_W-1:0]  bnd_code,
  output logic              cnt_en,
  output logic              dir_to_mem,
  output logic              multi,
  output logic              start
);

  logic [SIZE_W-1:0] blk_size;
  logic [1:0]        dma_sel;
  logic [SIZE_W:0]   rounded;
  logic [BEAT_W-1:0] raw_beats;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_size   <= '0;
      bnd_code   <= '0;
      dma_sel    <= '0;
      cnt_en     <= 1'b0;
      dir_to_mem <= 1'b0;
      multi      <= 1'b0;
    end else if (wr_en) begin
      case (sel)
        SEL_BSIZE: begin
          blk_size <= wdata[SIZE_W-1:0];
          bnd_code <= wdata[CFG_W-1:SIZE_W];
        end
        SEL_MODE: begin
          cnt_en     <= wdata[MODE_CNT_EN];
          dir_to_mem <= wdata[MODE_DIR];
          multi      <= wdata[MODE_MULTI];
        end
        SEL_HCTL: dma_sel <= wdata[HCTL_SEL_LO+1:HCTL_SEL_LO];
        default: ;
      endcase
    end
  end

  always_comb begin
    rounded   = {1'b0, blk_size} + (SIZE_W+1)'((1 << WORD_LOG2) - 1);
    raw_beats = rounded[SIZE_W:WORD_LOG2];
    blk_beats = (raw_beats == '0) ? BEAT_W'(1) : raw_beats;
  end

  assign start = wr_en && (sel == SEL_MODE) && wdata[MODE_DMA_EN] &&
                 (dma_sel == 2'b00) &&
                 !(wdata[MODE_MULTI] && wdata[MODE_CNT_EN] && count_zero);

endmodule

// File: rtl/sdma_addr_gen.sv
module sdma_addr_gen #(
  parameter int ADDR_W        = 32,
  parameter int WORD_BYTES    = 4,
  parameter int BEAT_W        = 11,
  parameter int BND_W         = 3,
  parameter int BND_BASE_LOG2 = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_beat,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  input  logic [BEAT_W-1:0] blk_beats,
  input  logic [BND_W-1:0]  bnd_code,
  output logic [ADDR_W-1:0] addr,
  output logic              blk_last,
  output logic              bnd_next
);

  logic [BEAT_W-1:0] beat_idx;
  logic [ADDR_W-1:0] step_addr;
  logic [ADDR_W-1:0] bnd_mask;

  always_comb begin
    step_addr = addr + ADDR_W'(WORD_BYTES);
    bnd_mask  = (ADDR_W'(1) << (BND_BASE_LOG2 + int'(bnd_code))) - ADDR_W'(1);
    bnd_next  = (step_addr & bnd_mask) == '0;
    blk_last  = beat_idx == (blk_beats - BEAT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr     <= '0;
      beat_idx <= '0;
    end else begin
      if (load) addr <= load_val;
      else if (step) addr <= step_addr;

      if (clr_beat) beat_idx <= '0;
      else if (step) beat_idx <= blk_last ? '0 : beat_idx + BEAT_W'(1);
    end
  end

endmodule

// File: rtl/sdma_status.sv
module sdma_status #(
  parameter int NUM = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] set_vec,
  input  logic           clr_en,
  input  logic [NUM-1:0] clr_vec,
  output logic [NUM-1:0] sts
);

  for (genvar g = 0; g < NUM; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts[g] <= 1'b0;
      else if (set_vec[g]) sts[g] <= 1'b1;
      else if (clr_en && clr_vec[g]) sts[g] <= 1'b0;
    end
  end

endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
  import sdma_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int WORD_BYTES    = 4,
  parameter int CNT_W         = 16,
  parameter int SIZE_W        = 12,
  parameter int BND_W         = 3,
  parameter int BND_BASE_LOG2 = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_write,
  input  logic              data_err,
  output logic              busy,
  output logic [CNT_W-1:0]  blocks_left,
  output logic              sts_xfer_done,
  output logic              sts_dma_pause,
  output logic              sts_error
);

  localparam int WORD_LOG2 = $clog2(WORD_BYTES);
  localparam int BEAT_W    = SIZE_W + 1 - WORD_LOG2;
  localparam int CFG_W     = SIZE_W + BND_W;

  eng_state_e        state;
  reg_sel_e          sel;
  logic              active, cfg_we, start, step, last_xfer;
  logic              addr_wr, blk_last, bnd_next;
  logic [BEAT_W-1:0] blk_beats;
  logic [BND_W-1:0]  bnd_code;
  logic              cnt_en, multi;
  logic [STS_NUM-1:0] set_vec, clr_vec, sts;

  assign sel       = reg_sel_e'(reg_sel);
  assign active    = state != ST_IDLE;
  assign busy      = active;
  assign cfg_we    = reg_we && !active;
  assign mem_valid = state == ST_RUN;
  assign step      = (state == ST_RUN) && mem_ready && !data_err;
  assign addr_wr   = reg_we && (sel == SEL_ADDR) && (state != ST_RUN);
  assign last_xfer = blk_last && (!multi || (cnt_en && blocks_left == CNT_W'(1)));

  sdma_cfg #(.SIZE_W(SIZE_W), .BND_W(BND_W), .WORD_LOG2(WORD_LOG2)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .sel(sel),
    .wdata(reg_wdata[CFG_W-1:0]), .count_zero(blocks_left == '0),
    .blk_beats(blk_beats), .bnd_code(bnd_code), .cnt_en(cnt_en),
    .dir_to_mem(mem_write), .multi(multi), .start(start)
  );

  sdma_addr_gen #(
    .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .BEAT_W(BEAT_W),
    .BND_W(BND_W), .BND_BASE_LOG2(BND_BASE_LOG2)
  ) u_addr (
    .clk(clk), .rst_n(rst_n), .clr_beat(start), .load(addr_wr),
    .load_val(reg_wdata[ADDR_W-1:0]), .step(step), .blk_beats(blk_beats),
    .bnd_code(bnd_code), .addr(mem_addr), .blk_last(blk_last), .bnd_next(bnd_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blocks_left <= '0;
    else if (cfg_we && sel == SEL_BCNT) blocks_left <= reg_wdata[CNT_W-1:0];
    else if (step && blk_last && cnt_en && blocks_left != '0)
      blocks_left <= blocks_left - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else begin
      case (state)
        ST_IDLE:  if (start) state <= ST_RUN;
        ST_RUN: begin
          if (data_err) state <= ST_IDLE;
          else if (step) begin
            if (last_xfer) state <= ST_IDLE;
            else if (bnd_next) state <= ST_PAUSE;
          end
        end
        ST_PAUSE: begin
          if (data_err) state <= ST_IDLE;
          else if (addr_wr) state <= ST_RUN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    set_vec           = '0;
    set_vec[STS_DONE] = step && last_xfer;
    set_vec[STS_DMA]  = step && !last_xfer && bnd_next;
    set_vec[STS_ERR]  = active && data_err;
    clr_vec           = '0;
    clr_vec[STS_DONE] = reg_wdata[STS_DONE_BIT];
    clr_vec[STS_DMA]  = reg_wdata[STS_DMA_BIT];
    clr_vec[STS_ERR]  = reg_wdata[STS_ERR_BIT];
  end

  sdma_status #(.NUM(STS_NUM)) u_sts (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
    .clr_en(reg_we && sel == SEL_STATUS), .clr_vec(clr_vec), .sts(sts)
  );

  assign sts_xfer_done = sts[STS_DONE];
  assign sts_dma_pause = sts[STS_DMA];
  assign sts_error     = sts[STS_ERR];

endmodule

// File: rtl/sdma_engine_chk.sv
module sdma_engine_chk #(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  parameter int CNT_W      = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              data_err,
  input logic              busy,
  input logic [CNT_W-1:0]  blocks_left,
  input logic              sts_xfer_done,
  input logic              sts_dma_pause,
  input logic              sts_error
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && !data_err) |=> (mem_valid && $stable(mem_addr))); // R3

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !data_err) |=>
      (mem_addr == $past(mem_addr) + ADDR_W'(WORD_BYTES))); // R3

  AST_PAUSE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_dma_pause) |-> (!mem_valid && busy)); // R6

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_xfer_done) |-> !busy); // R5

  AST_ERR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_error) |-> (!busy && !$rose(sts_xfer_done))); // R10

  AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(mem_valid && mem_ready)) |=> $stable(blocks_left)); // R11

endmodule

bind sdma_engine sdma_engine_chk #(
  .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/sdma_engine_test.sv
module sdma_engine_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic        mem_valid, mem_write, busy;
  logic        mem_ready = 1'b0;
  logic        data_err = 1'b0;
  logic [31:0] mem_addr;
  logic [15:0] blocks_left;
  logic        sts_xfer_done, sts_dma_pause, sts_error;

  int n_chk = 0;
  int n_err = 0;

  logic [31:0] m_addr;
  int          m_beat, m_nb, m_cnt, m_code;
  bit          m_multi, m_cnten, m_dir, m_run;

  always #2 clk = ~clk;

  sdma_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_write(mem_write), .data_err(data_err),
    .busy(busy), .blocks_left(blocks_left), .sts_xfer_done(sts_xfer_done),
    .sts_dma_pause(sts_dma_pause), .sts_error(sts_error)
  );

  function automatic int f_beats(input int size);
    int b = (size + 3) / 4;
    return (b == 0) ? 1 : b;
  endfunction

  function automatic bit f_bnd_hit(input logic [31:0] a, input int code);
    logic [31:0] mask = (32'h1 << (12 + code)) - 32'h1;
    return (a & mask) == 32'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [31:0] data);
    reg_we = 1'b1; reg_sel = 3'(sel); reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic clear_all();
    wr(5, 32'h0000_8009);
    chk("R9 clear all", {sts_error, sts_dma_pause, sts_xfer_done}, 3'b000);
  endtask

  task automatic setup(input logic [31:0] addr, input int size, input int cnt,
                       input int code, input bit multi, input bit cnten, input bit dir);
    m_addr = addr; m_nb = f_beats(size); m_beat = 0; m_cnt = cnt; m_code = code;
    m_multi = multi; m_cnten = cnten; m_dir = dir;
    wr(1, {17'b0, 3'(code), 12'(size)});
    wr(2, 32'(cnt));
    wr(0, addr);
    wr(3, {26'b0, multi, dir, 2'b00, cnten, 1'b1});
    chk("R2 start", busy, 1'b1);
  endtask

  task automatic drive(input int err_at, input logic [31:0] resume_base);
    int it = 0;
    bit rdy, inj, last;
    m_run = 1;
    while (m_run && it < 20000) begin
      chk("R3 valid", mem_valid, 1'b1);
      chk("R3 addr", mem_addr, m_addr);
      chk("R13 dir", mem_write, m_dir);
      rdy = ($urandom % 4) != 0;
      inj = (it == err_at);
      mem_ready = rdy; data_err = inj;
      @(negedge clk);
      mem_ready = 1'b0; data_err = 1'b0; it++;
      if (inj) begin
        chk("R10 abort busy", busy, 1'b0);
        chk("R10 error set", sts_error, 1'b1);
        chk("R10 no done", sts_xfer_done, 1'b0);
        m_run = 0;
      end else if (rdy) begin
        m_addr += 32'd4; m_beat++; last = 0;
        if (m_beat == m_nb) begin
          m_beat = 0;
          if (m_cnten && m_cnt != 0) m_cnt--;
          last = !m_multi || (m_cnten && m_cnt == 0);
        end
        if (last) begin
          chk("R5 busy low", busy, 1'b0);
          chk("R5 done", sts_xfer_done, 1'b1);
          chk("R8 no pause at end", sts_dma_pause, 1'b0);
          chk("R4 blocks_left", blocks_left, 32'(m_cnt));
          m_run = 0;
        end else if (f_bnd_hit(m_addr, m_code)) begin
          chk("R6 pause set", sts_dma_pause, 1'b1);
          chk("R6 valid low", mem_valid, 1'b0);
          mem_ready = 1'b1;
          repeat (3) @(negedge clk);
          mem_ready = 1'b0;
          chk("R6 still paused", {busy, mem_valid}, 2'b10);
          chk("R4 count at pause", blocks_left, 32'(m_cnt));
          wr(5, 32'h0000_0008);
          chk("R9 pause cleared", sts_dma_pause, 1'b0);
          m_addr = resume_base + 32'(($urandom % 16) * 4);
          wr(0, m_addr);
          chk("R7 resumed", mem_valid, 1'b1);
        end
      end
    end
    if (it >= 20000) chk("R5 transfer ended", 1'b0, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R1 reset outputs", {busy, mem_valid, sts_xfer_done, sts_dma_pause, sts_error}, 5'b0);
    chk("R1 reset count", blocks_left, 32'h0);
    chk("R1 reset addr", mem_addr, 32'h0);

    // R2: non-SDMA select, enable clear, zero count with counted multi-block
    wr(4, 32'h0000_0010);
    wr(3, 32'h0000_0001);
    repeat (2) @(negedge clk);
    chk("R2 adma select no start", {busy, mem_valid}, 2'b00);
    wr(4, 32'h0);
    wr(3, 32'h0000_0000);
    chk("R2 enable clear no start", busy, 1'b0);
    wr(2, 32'h0);
    wr(3, 32'h0000_0023);
    chk("R2 zero count no start", busy, 1'b0);

    // R10: error while idle has no effect
    data_err = 1'b1; @(negedge clk); data_err = 1'b0;
    chk("R10 idle error ignored", sts_error, 1'b0);

    // R5/R4: single block with count left over
    setup(32'h1000_0100, 16, 5, 0, 0, 1, 1);
    drive(-1, 32'h0);
    clear_all();

    // R4: zero-size and odd-size blocks
    setup(32'h0000_2000, 0, 2, 0, 1, 1, 0);
    drive(-1, 32'h0);
    clear_all();
    setup(32'h0000_2100, 10, 3, 0, 1, 1, 1);
    drive(-1, 32'h0);
    clear_all();

    // R6/R7: pause at 4 KiB then resume elsewhere
    setup(32'h0000_0FF0, 32, 2, 0, 1, 1, 0);
    drive(-1, 32'h0008_0000);
    clear_all();

    // R6: code 1, 4 KiB crossing not a boundary, 8 KiB crossing is
    setup(32'h0000_0FF8, 8, 2, 1, 1, 1, 1);
    drive(-1, 32'h0009_0000);
    clear_all();
    setup(32'h0000_3FF8, 8, 3, 1, 1, 1, 1);
    drive(-1, 32'h000A_0000);
    clear_all();

    // R8: final beat lands on boundary
    setup(32'h0000_0FF0, 16, 1, 0, 0, 1, 0);
    drive(-1, 32'h0);
    clear_all();

    // R11/R7: writes while running ignored
    setup(32'h0000_0100, 64, 4, 0, 1, 1, 1);
    wr(0, 32'hDEAD_0000);
    wr(2, 32'd9);
    wr(1, 32'h0000_0004);
    chk("R7 addr write while running ignored", mem_addr, 32'h0000_0100);
    chk("R11 count write while busy ignored", blocks_left, 32'd4);
    drive(-1, 32'h0);
    chk("R11 block size unchanged", blocks_left, 32'd0);

    // R9: selective write-1-to-clear
    wr(5, 32'h0000_0008);
    chk("R9 other bit kept", sts_xfer_done, 1'b1);
    wr(5, 32'h0000_0000);
    chk("R9 zero write no effect", sts_xfer_done, 1'b1);
    wr(5, 32'h0000_0001);
    chk("R9 done cleared", sts_xfer_done, 1'b0);

    // R10: error mid-transfer
    setup(32'h0000_0400, 16, 3, 0, 1, 1, 0);
    drive(5, 32'h0);
    clear_all();

    // R12: endless multi-block without counting, stopped by error
    setup(32'h0000_0600, 8, 2, 0, 1, 0, 1);
    drive(12, 32'h0);
    chk("R12 count held", blocks_left, 32'd2);
    clear_all();

    // Random transfers near boundaries
    for (int n = 0; n < 14; n++) begin
      int k = 1 + ($urandom % 200);
      logic [31:0] a = 32'(k * 4096 - 4 * ($urandom % 12));
      setup(a, $urandom % 40, 1 + ($urandom % 4), $urandom % 2,
            1'($urandom % 2), 1'b1, 1'($urandom % 2));
      drive(-1, 32'h0040_0000 + 32'(n * 32'h1000));
      clear_all();
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule